// File: doc/BRIEF.md
# Debug Request Conditioning Wrapper

This block sits between one output line of a cross-trigger matrix and the halt-request pin of a processor core. When the matrix raises its trigger line, the wrapper raises a halt request to the core and keeps it raised until the core reports that it has entered debug state. The core's debug-state indication is a combinational output. The wrapper therefore passes it through a chain of registers before using it. One register is enough when both sides share a clock. A longer chain acts as a synchronizer when they do not.

The registered debug-state indication serves three purposes. It blocks the halt request, because a core already in debug state must not see a new request. It is returned to the matrix as a trigger input, so a debug entry the wrapper never asked for, such as a breakpoint, still reaches the other cores. It also drives the acknowledge for the matrix's trigger line. A trigger that arrives while the core is already halted is acknowledged and dropped, not queued. A parameter selects whether the request is held as a level or shaped into a single-clock pulse.

Top module: `halt_req_cond`

## Requirements
- R1: While reset is asserted (rstN low), and in the first cycle after it is released with all inputs low, haltReq, trigOutAck and trigIn are all 0.
- R2: With the core not in debug state and no earlier trigger still acknowledged, trigOut sampled high at a rising clock edge makes haltReq high right after that edge. In level mode (PULSE_MODE=0), haltReq stays high until the registered debug state reaches 1.
- R3: coreAckRaw reaches the rest of the block only after SYNC_STAGES register stages. trigIn equals coreAckRaw as sampled SYNC_STAGES rising edges earlier. Until then, a pending haltReq is unaffected.
- R4: haltReq is 0 in every cycle in which trigIn (the registered debug state) is 1.
- R5: trigOutAck is 1 when trigOut and trigIn are both 1. It then stays 1, even after trigIn falls, for as long as trigOut stays high. It is 0 whenever trigOut is 0.
- R6: Once a request has been acknowledged, holding trigOut high creates no new request. After trigOut falls and rises again, a new request is made.
- R7: A trigger sampled while trigIn is 1 is dropped. No haltReq is raised for it, not even after trigIn falls, and trigOutAck is raised for it.
- R8: A debug entry without any request (coreAckRaw high while trigOut is low) appears on trigIn. haltReq and trigOutAck both stay 0.
- R9: In pulse mode (PULSE_MODE=1), each accepted trigger makes haltReq high for exactly one clock cycle.
- R10: Once raised, a request stays pending even if trigOut falls before the core acknowledges. In level mode, haltReq stays high until trigIn is 1, and the request is cleared by that acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigOut | input | 1 | Trigger line from the cross-trigger matrix, held until acknowledged |
| coreAckRaw | input | 1 | Combinational debug-state indication from the core |
| haltReq | output | 1 | Halt request to the core |
| trigOutAck | output | 1 | Acknowledge of trigOut back to the matrix |
| trigIn | output | 1 | Registered debug state, returned to the matrix as a trigger input |

## Verification
The bench builds two copies of the block. The first has SYNC_STAGES=2 and PULSE_MODE=0. The two-stage chain leaves a visible cycle in which the raw acknowledge is already high but the request must still be held, which makes the R3 latency and the R4 gating observable one at a time. The second has SYNC_STAGES=1 and PULSE_MODE=1. It covers the same-clock single-register path and the single-cycle pulse, including a second pulse after a full handshake.

// File: rtl/halt_req_pkg.sv
package halt_req_pkg;

  // Strobes from the control to the datapath registers
  typedef struct packed {
    logic setPend;   // accept a new trigger as a pending request
    logic clrPend;   // core entered debug state: request served
    logic setHold;   // remember that trigOut has been acknowledged
    logic clrHold;   // trigOut released: forget the acknowledge
  } strobe_t;

endpackage

// File: rtl/halt_req_ctrl.sv
module halt_req_ctrl
  import halt_req_pkg::*;
(
  input  logic    trigOut,
  input  logic    ackReg,
  input  logic    pending,
  input  logic    ackHold,
  output strobe_t strobe
);

  logic alreadyServed;

  always_comb begin
    alreadyServed  = ackHold;
    strobe         = '0;
    // New request only when idle, core not halted, and trigger not yet served
    strobe.setPend = trigOut && !ackReg && !pending && !alreadyServed;
    strobe.clrPend = pending && ackReg;
    strobe.setHold = trigOut && ackReg && !ackHold;
    strobe.clrHold = !trigOut && ackHold;
  end

endmodule

// File: rtl/halt_req_dp.sv
module halt_req_dp
  import halt_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit PULSE_MODE  = 1'b0
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    coreAckRaw,
  input  logic    trigOut,
  input  strobe_t strobe,
  output logic    ackReg,
  output logic    pending,
  output logic    ackHold,
  output logic    haltReq,
  output logic    trigOutAck
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] ackPipe;

  // Register chain on the combinational acknowledge from the core
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gAckStage
      if (gi == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ackPipe[0] <= 1'b0;
          else       ackPipe[0] <= coreAckRaw;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ackPipe[gi] <= 1'b0;
          else       ackPipe[gi] <= ackPipe[gi-1];
        end
      end
    end
  endgenerate

  assign ackReg = ackPipe[LAST];

  // Pending request register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pending <= 1'b0;
    else if (strobe.clrPend) pending <= 1'b0;
    else if (strobe.setPend) pending <= 1'b1;
  end

  // Acknowledge-hold register for the trigger handshake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ackHold <= 1'b0;
    else if (strobe.clrHold) ackHold <= 1'b0;
    else if (strobe.setHold) ackHold <= 1'b1;
  end

  assign trigOutAck = trigOut && (ackReg || ackHold);

  // Request shaping: held level or single-cycle pulse
  generate
    if (PULSE_MODE) begin : gPulse
      logic pendingQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pendingQ <= 1'b0;
        else       pendingQ <= pending;
      end
      assign haltReq = pending && !pendingQ && !ackReg;
    end else begin : gLevel
      assign haltReq = pending && !ackReg;
    end
  endgenerate

endmodule

// File: rtl/halt_req_cond.sv
module halt_req_cond
  import halt_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit PULSE_MODE  = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigOut,
  input  logic coreAckRaw,
  output logic haltReq,
  output logic trigOutAck,
  output logic trigIn
);

  strobe_t strobe;
  logic    ackReg;
  logic    pending;
  logic    ackHold;

  halt_req_ctrl i_ctrl (
    .trigOut (trigOut),
    .ackReg  (ackReg),
    .pending (pending),
    .ackHold (ackHold),
    .strobe  (strobe)
  );

  halt_req_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .PULSE_MODE  (PULSE_MODE)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .coreAckRaw (coreAckRaw),
    .trigOut    (trigOut),
    .strobe     (strobe),
    .ackReg     (ackReg),
    .pending    (pending),
    .ackHold    (ackHold),
    .haltReq    (haltReq),
    .trigOutAck (trigOutAck)
  );

  assign trigIn = ackReg;

  // R2: a rising request is always caused by a sampled trigger
  assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(haltReq) |-> $past(trigOut));

  // R2: in level mode a request is held until the core is halted
  assert_hold_until_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!PULSE_MODE && haltReq && !trigIn) |=> (haltReq || trigIn));

  // R4: no request while the registered debug state is set
  assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    trigIn |-> !haltReq);

  // R5: acknowledge persists while the trigger is held
  assert_ack_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trigOutAck && trigOut) |=> (trigOutAck || !trigOut));

  // R5: no acknowledge without a trigger
  assert_ack_needs_trig_R5: assert property (@(posedge clk) disable iff (!rstN)
    !trigOut |-> !trigOutAck);

  // R9: pulse mode requests last one cycle
  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    (PULSE_MODE && haltReq) |=> !haltReq);

endmodule

// File: tb/test_halt_req_cond.sv
`timescale 1ns/1ps
module test_halt_req_cond;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aTrig = 1'b0, aAck = 1'b0;
  logic bTrig = 1'b0, bAck = 1'b0;
  logic aReq, aTAck, aTIn;
  logic bReq, bTAck, bTIn;
  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  halt_req_cond #(.SYNC_STAGES(2), .PULSE_MODE(1'b0)) i_halt_req_cond (
    .clk(clk), .rstN(rstN), .trigOut(aTrig), .coreAckRaw(aAck),
    .haltReq(aReq), .trigOutAck(aTAck), .trigIn(aTIn));

  halt_req_cond #(.SYNC_STAGES(1), .PULSE_MODE(1'b1)) i_halt_req_cond_pulse (
    .clk(clk), .rstN(rstN), .trigOut(bTrig), .coreAckRaw(bAck),
    .haltReq(bReq), .trigOutAck(bTAck), .trigIn(bTIn));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    step(1);
    check("R1", "A haltReq in reset", aReq, 1'b0);
    check("R1", "A trigOutAck in reset", aTAck, 1'b0);
    check("R1", "B trigIn in reset", bTIn, 1'b0);
    rstN = 1'b1;
    step(1);
    check("R1", "A haltReq after reset", aReq, 1'b0);
    check("R1", "A trigIn after reset", aTIn, 1'b0);
    check("R1", "B haltReq after reset", bReq, 1'b0);
    check("R1", "B trigOutAck after reset", bTAck, 1'b0);
  endtask

  task automatic testHandshake();
    aTrig = 1'b1;
    step(1);
    check("R2", "haltReq after trigger", aReq, 1'b1);
    aAck = 1'b1;
    step(1);
    check("R3", "haltReq held during sync", aReq, 1'b1);
    check("R3", "trigIn not yet set", aTIn, 1'b0);
    step(1);
    check("R3", "trigIn after two stages", aTIn, 1'b1);
    check("R4", "haltReq gated by debug state", aReq, 1'b0);
    check("R5", "trigOutAck on ack", aTAck, 1'b1);
    aAck = 1'b0;
    step(1);
    check("R3", "trigIn still high one stage in", aTIn, 1'b1);
    step(1);
    check("R3", "trigIn falls", aTIn, 1'b0);
    check("R6", "no re-request while trigger held", aReq, 1'b0);
    check("R5", "trigOutAck held after ack falls", aTAck, 1'b1);
    step(2);
    check("R6", "still no re-request", aReq, 1'b0);
    aTrig = 1'b0;
    step(1);
    check("R5", "trigOutAck low after trigger falls", aTAck, 1'b0);
    aTrig = 1'b1;
    step(1);
    check("R6", "new request after retrigger", aReq, 1'b1);
    aAck = 1'b1;
    step(2);
    check("R4", "second request gated", aReq, 1'b0);
    aTrig = 1'b0;
    aAck = 1'b0;
    step(3);
  endtask

  task automatic testEarlyRelease();
    aTrig = 1'b1;
    step(1);
    check("R10", "request raised", aReq, 1'b1);
    aTrig = 1'b0;
    step(3);
    check("R10", "request held after trigger falls", aReq, 1'b1);
    aAck = 1'b1;
    step(2);
    check("R10", "request ends on ack", aReq, 1'b0);
    check("R5", "no trigOutAck without trigger", aTAck, 1'b0);
    aAck = 1'b0;
    step(3);
    check("R10", "request cleared by ack", aReq, 1'b0);
  endtask

  task automatic testUnsolicited();
    aAck = 1'b1;
    step(2);
    check("R8", "trigIn on breakpoint entry", aTIn, 1'b1);
    check("R8", "no haltReq", aReq, 1'b0);
    check("R8", "no trigOutAck", aTAck, 1'b0);
    aAck = 1'b0;
    step(2);
    check("R8", "trigIn clears", aTIn, 1'b0);
  endtask

  task automatic testDropped();
    aAck = 1'b1;
    step(2);
    aTrig = 1'b1;
    step(1);
    check("R7", "no haltReq while halted", aReq, 1'b0);
    check("R7", "dropped trigger acknowledged", aTAck, 1'b1);
    aAck = 1'b0;
    step(3);
    check("R7", "no haltReq after debug exit", aReq, 1'b0);
    check("R7", "trigOutAck still held", aTAck, 1'b1);
    aTrig = 1'b0;
    step(1);
    check("R7", "trigOutAck released", aTAck, 1'b0);
    check("R7", "no late request", aReq, 1'b0);
  endtask

  task automatic testPulse();
    bTrig = 1'b1;
    step(1);
    check("R9", "pulse first cycle", bReq, 1'b1);
    step(1);
    check("R9", "pulse ends after one cycle", bReq, 1'b0);
    step(2);
    check("R9", "no further pulse", bReq, 1'b0);
    bAck = 1'b1;
    step(1);
    check("R3", "single-stage trigIn", bTIn, 1'b1);
    check("R5", "B trigOutAck", bTAck, 1'b1);
    bTrig = 1'b0;
    bAck = 1'b0;
    step(1);
    check("R5", "B trigOutAck released", bTAck, 1'b0);
    check("R3", "B trigIn released", bTIn, 1'b0);
    bTrig = 1'b1;
    step(1);
    check("R9", "second pulse", bReq, 1'b1);
    step(1);
    check("R9", "second pulse one cycle", bReq, 1'b0);
    bAck = 1'b1;
    step(1);
    bTrig = 1'b0;
    bAck = 1'b0;
    step(2);
  endtask

  initial begin
    testReset();
    testHandshake();
    testEarlyRelease();
    testUnsolicited();
    testDropped();
    testPulse();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule